// File: doc/BRIEF.md
# Address-Match Breakpoint Controller

This block watches the instruction address that a CPU core puts out and raises a breakpoint request when that address equals a programmed 16-bit break address. Software can also force a break by setting a flag in the control register. Both sources feed one break-active state. A single-cycle breakpoint pulse goes to the system integration logic, which then makes the core run a software-interrupt instruction. The state stays set until the core reports a return-from-interrupt, or until software clears the flag.

While a break is active, the block holds off the watchdog. It also drives the address of the high byte of the break vector. That address is one fixed value in normal operation and another in monitor mode. The low byte of the vector sits at the next address. Three byte-wide registers are reachable through a simple select/write/read interface: the break address high byte, the break address low byte, and a control byte.

Top module: `brk_ctrl`

## Requirements
- R1: After reset, every register reads 0, the break-active flag is 0, and the breakpoint pulse and watchdog hold are low.
- R2: Select 0 reads and writes the break address high byte, select 1 the low byte, and select 2 the control byte (bit 7 enable, bit 6 break-active, all other bits read 0). Select 3 reads 0 and ignores writes.
- R3: When enable is set, the address strobe is high and the bus address equals the stored break address, the breakpoint pulse is high for exactly the next cycle and the break-active flag becomes 1 in that same cycle.
- R4: No address break occurs when enable is clear, when the address strobe is low, or when the address differs from the break address.
- R5: Writing select 2 with bit 6 set starts a break (pulse plus active flag) whatever the state of enable.
- R6: A request that arrives while the break is already active produces no further pulse. This covers an address match held over several cycles.
- R7: A return-from-interrupt strobe clears the break-active flag on the next edge. So does a write to select 2 with bit 6 clear.
- R8: If a break request and a clear (strobe or write) fall in the same cycle, the request wins and the flag stays or becomes 1.
- R9: The vector output is 0xFFFC when monitor mode is low and 0xFEFC when it is high. It follows monitor mode in the same cycle.
- R10: The watchdog hold output equals the break-active flag, so it is high in the cycle of the breakpoint pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | Instruction address from the CPU |
| cpu_addr_vld | input | 1 | Marks cpu_addr as a CPU-generated address this cycle |
| cpu_rti | input | 1 | Return-from-interrupt strobe |
| monitor_mode | input | 1 | Selects the monitor vector |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_sel |
| bkpt_pulse | output | 1 | Single-cycle breakpoint request |
| vector_addr | output | 16 | Address of the vector high byte |
| wdog_hold | output | 1 | Holds off the watchdog |

## Verification
The bench aims at a match held over many cycles: a design that detects the level instead of the edge would pulse again on every cycle. It drives a clear and a request in the same cycle. A design with the wrong priority would drop the break, and the watchdog hold with it. It writes the address and the control byte in the same cycle as a matching address. A design that compared against the incoming write data instead of the stored value would fire early. It sets the force bit with enable clear. A design that gated the software path with enable would fail to break.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    SEL_AHI  = 2'd0,
    SEL_ALO  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } brk_sel_e;

  localparam int CTL_EN_BIT  = 7;
  localparam int CTL_ACT_BIT = 6;
endpackage

// File: rtl/brk_rst_sync.sv
module brk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              active,
  output logic [ADDR_W-1:0] brk_addr,
  output logic              enable,
  output logic [DATA_W-1:0] rdata,
  output logic              sw_set,
  output logic              sw_clr
);
  brk_sel_e          sel_e;
  logic [DATA_W-1:0] ahi_q, ahi_d, alo_q, alo_d;
  logic              en_q, en_d;
  logic              ahi_ce, alo_ce, ctl_ce;

  assign sel_e  = brk_sel_e'(sel);
  assign ahi_ce = wr && (sel_e == SEL_AHI);
  assign alo_ce = wr && (sel_e == SEL_ALO);
  assign ctl_ce = wr && (sel_e == SEL_CTL);

  always_comb begin
    ahi_d = ahi_q;
    alo_d = alo_q;
    en_d  = en_q;
    if (ahi_ce) ahi_d = wdata;
    if (alo_ce) alo_d = wdata;
    if (ctl_ce) en_d  = wdata[CTL_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ahi_q <= '0;
      alo_q <= '0;
      en_q  <= 1'b0;
    end else begin
      ahi_q <= ahi_d;
      alo_q <= alo_d;
      en_q  <= en_d;
    end
  end

  assign sw_set   = ctl_ce &&  wdata[CTL_ACT_BIT];
  assign sw_clr   = ctl_ce && !wdata[CTL_ACT_BIT];
  assign brk_addr = {ahi_q, alo_q};
  assign enable   = en_q;

  always_comb begin
    rdata = '0;
    unique case (sel_e)
      SEL_AHI: rdata = ahi_q;
      SEL_ALO: rdata = alo_q;
      SEL_CTL: begin
        rdata[CTL_EN_BIT]  = en_q;
        rdata[CTL_ACT_BIT] = active;
      end
      SEL_NONE: rdata = '0;
    endcase
  end

  AST_AHI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ahi_ce |=> (brk_addr[ADDR_W-1:DATA_W] == $past(wdata))); // R2
  AST_CTL_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ce |=> (enable == $past(wdata[CTL_EN_BIT]))); // R2
endmodule

// File: rtl/brk_match.sv
module brk_match #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] brk_addr,
  input  logic              enable,
  output logic              hit
);
  assign hit = enable && addr_vld && (addr == brk_addr);
endmodule

// File: rtl/brk_state.sv
module brk_state (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_hit,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic rti,
  output logic active,
  output logic pulse
);
  logic req, act_q, act_d, pulse_q, pulse_d;

  assign req = addr_hit || sw_set;

  always_comb begin
    pulse_d = req && !act_q;
    act_d   = act_q;
    if (req)                 act_d = 1'b1;
    else if (rti || sw_clr)  act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      pulse_q <= pulse_d;
    end
  end

  assign active = act_q;
  assign pulse  = pulse_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R6
  AST_PULSE_WITH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> active); // R3
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rti || sw_clr) && !req) |=> !active); // R7
  AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> active); // R8
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !req) |=> !active); // R4
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter logic [15:0] NRM_VEC = 16'hFFFC,
  parameter logic [15:0] MON_VEC = 16'hFEFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_addr_vld,
  input  logic        cpu_rti,
  input  logic        monitor_mode,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        bkpt_pulse,
  output logic [15:0] vector_addr,
  output logic        wdog_hold
);
  localparam int ADDR_W = 2 * DATA_W;

  logic              srst_n;
  logic [ADDR_W-1:0] brk_addr;
  logic              enable, sw_set, sw_clr, hit, active;

  brk_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  brk_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr       (reg_wr),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .active   (active),
    .brk_addr (brk_addr),
    .enable   (enable),
    .rdata    (reg_rdata),
    .sw_set   (sw_set),
    .sw_clr   (sw_clr)
  );

  brk_match #(.ADDR_W(ADDR_W)) u_match (
    .addr     (cpu_addr),
    .addr_vld (cpu_addr_vld),
    .brk_addr (brk_addr),
    .enable   (enable),
    .hit      (hit)
  );

  brk_state u_state (
    .clk      (clk),
    .rst_n    (srst_n),
    .addr_hit (hit),
    .sw_set   (sw_set),
    .sw_clr   (sw_clr),
    .rti      (cpu_rti),
    .active   (active),
    .pulse    (bkpt_pulse)
  );

  assign vector_addr = monitor_mode ? MON_VEC : NRM_VEC;
  assign wdog_hold   = active;

  AST_ACTIVE_RISE_PULSES: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(wdog_hold) |-> bkpt_pulse); // R10
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!srst_n)
    (vector_addr == NRM_VEC) || (vector_addr == MON_VEC)); // R9
endmodule

// File: tb/brk_ctrl_tb.sv
module brk_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_addr_vld, cpu_rti, monitor_mode, reg_wr;
  logic [1:0]  reg_sel;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        bkpt_pulse, wdog_hold;
  logic [15:0] vector_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] m_hi, m_lo;
  logic       m_en, m_act, m_pulse;

  always #5 clk = ~clk;

  brk_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_addr_vld(cpu_addr_vld),
    .cpu_rti(cpu_rti), .monitor_mode(monitor_mode), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bkpt_pulse(bkpt_pulse), .vector_addr(vector_addr), .wdog_hold(wdog_hold)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [1:0] s);
    case (s)
      2'd0: return m_hi;
      2'd1: return m_lo;
      2'd2: return {m_en, m_act, 6'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] exp_vec(logic mon);
    return mon ? 16'hFEFC : 16'hFFFC;
  endfunction

  task automatic step();
    logic req, ctl_wr;
    ctl_wr  = reg_wr && reg_sel == 2'd2;
    req     = (m_en && cpu_addr_vld && cpu_addr == {m_hi, m_lo}) ||
              (ctl_wr && reg_wdata[6]);
    m_pulse = req && !m_act;
    if (req) m_act = 1'b1;
    else if (cpu_rti || (ctl_wr && !reg_wdata[6])) m_act = 1'b0;
    if (reg_wr && reg_sel == 2'd0) m_hi = reg_wdata;
    if (reg_wr && reg_sel == 2'd1) m_lo = reg_wdata;
    if (ctl_wr) m_en = reg_wdata[7];
    @(posedge clk);
    #1;
    chk("R3 pulse", bkpt_pulse, m_pulse);
    chk("R10 wdog_hold", wdog_hold, m_act);
    chk("R2 rdata", reg_rdata, exp_rd(reg_sel));
    chk("R9 vector", vector_addr, exp_vec(monitor_mode));
    reg_wr = 1'b0; cpu_rti = 1'b0;
  endtask

  task automatic wr_reg(logic [1:0] s, logic [7:0] d);
    reg_sel = s; reg_wr = 1'b1; reg_wdata = d;
    step();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0B7C));
    rst_n = 1'b0; cpu_addr = '0; cpu_addr_vld = 0; cpu_rti = 0;
    monitor_mode = 0; reg_sel = 0; reg_wr = 0; reg_wdata = 0;
    m_hi = 0; m_lo = 0; m_en = 0; m_act = 0; m_pulse = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      reg_sel = 2'(s); #1;
      chk("R1 reset rdata", reg_rdata, 8'h00);
    end
    chk("R1 reset pulse", bkpt_pulse, 1'b0);
    chk("R1 reset hold", wdog_hold, 1'b0);

    // R2 address registers, unused select ignores writes
    wr_reg(2'd0, 8'h12);
    wr_reg(2'd1, 8'h34);
    wr_reg(2'd3, 8'hFF);
    chk("R2 sel3 reads 0", reg_rdata, 8'h00);
    reg_sel = 2'd0; #1; chk("R2 hi kept", reg_rdata, 8'h12);

    // R4 enable clear: no break on match
    cpu_addr = 16'h1234; cpu_addr_vld = 1; step();
    chk("R4 no break when disabled", wdog_hold, 1'b0);

    // enable, then R4 strobe low and differing address
    reg_sel = 2'd2; wr_reg(2'd2, 8'h80);
    cpu_addr_vld = 0; step();
    chk("R4 strobe low", bkpt_pulse, 1'b0);
    cpu_addr_vld = 1; cpu_addr = 16'h1235; step();
    chk("R4 address differs", bkpt_pulse, 1'b0);

    // R3 and R6 held match
    cpu_addr = 16'h1234; step();
    chk("R3 pulse on match", bkpt_pulse, 1'b1);
    chk("R10 hold with pulse", wdog_hold, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R6 no repulse", bkpt_pulse, 1'b0);
    end

    // R8 rti with held match: request wins
    cpu_rti = 1; step();
    chk("R8 request wins", wdog_hold, 1'b1);

    // R7 rti clears
    cpu_addr_vld = 0; cpu_rti = 1; step();
    chk("R7 rti clears", wdog_hold, 1'b0);

    // R5 software break with enable clear
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd2, 8'h40);
    chk("R5 sw pulse", bkpt_pulse, 1'b1);
    chk("R5 sw active", reg_rdata, 8'h40);
    wr_reg(2'd2, 8'h40);
    chk("R6 sw no repulse", bkpt_pulse, 1'b0);
    // R7 write 0 clears
    wr_reg(2'd2, 8'h00);
    chk("R7 write clears", wdog_hold, 1'b0);

    // R9 monitor mode
    monitor_mode = 1; #1;
    chk("R9 monitor vector", vector_addr, 16'hFEFC);
    monitor_mode = 0; #1;
    chk("R9 normal vector", vector_addr, 16'hFFFC);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cpu_addr_vld = ($urandom_range(0, 3) != 0);
      cpu_addr     = ($urandom_range(0, 2) == 0) ? {m_hi, m_lo} : 16'($urandom);
      cpu_rti      = ($urandom_range(0, 9) == 0);
      monitor_mode = 1'($urandom);
      reg_sel      = 2'($urandom);
      reg_wr       = (r < 12);
      reg_wdata    = 8'($urandom);
      if (reg_wr && reg_sel == 2'd2 && $urandom_range(0, 1) == 0)
        reg_wdata[6] = 1'b0;
      step();
    end

    done = 1;
    summary();
  end
endmodule